// File: doc/BRIEF.md
# Supply-Fail Monitor with Write Lockout

This block is the digital half of a supply supervisor for a nonvolatile memory that also holds a timekeeper. Three comparators report the supply against three levels: an early-warning level, a lower write-lockout level, and the backup-source level. A fourth input reports whether the voltage reference behind those comparators is alive. Each of these four inputs is resynchronised and filtered. From them the block derives a power-fail condition, a lockout state and a supply selection for the clock domain.

The power-fail condition sets a sticky flag in a flags/control register. A read of that register clears the flag once the supply has recovered. An enable bit in the same register lets the flag pull an active-low interrupt request. While lockout holds, the block refuses memory-array and clock-register accesses and ignores register reads and writes. When the supply comes back up, the chip enable must have been seen deasserted (high) before accesses are let through again.

Top module: `pfail_monitor`

## Requirements
- R1: A filtered supply-below-warning indication drives `pfail_o` high and sets the sticky flag, which reads back as bit 5 of the register at address 0x7FF0.
- R2: Bit 0 of the register at 0x7FF0 is a write/readable interrupt enable, reset to 0. `irq_n_o` is low exactly when that enable and the sticky flag are both 1.
- R3: While `lock_o` is high, `acc_grant_o` stays low and register reads and writes are ignored. An ignored read returns 0 and an ignored write leaves the register unchanged.
- R4: A lockout indication without a warning indication is still handled as lockout, and it also raises the power-fail condition.
- R5: `bak_sel_o` follows the filtered below-backup indication, whatever the state of the other two comparators.
- R6: When the warning indication clears, `pfail_o` falls, but the flag stays 1 until the flags register is read. The read returns the flag value from before the clear.
- R7: After the lockout indication clears, `lock_o` stays high until `ce_n_i` has been sampled high at least once since lockout was entered.
- R8: When `ref_ok_i` is low, the block treats the supply as below all thresholds: power-fail, backup select and lockout are all asserted.
- R9: A flags read while the power-fail condition is still present leaves the flag set, because set wins over clear.
- R10: Each comparator input is ignored until it has held a new level for FILT_LEN consecutive synchronised cycles. An accepted change shows on `pfail_o`, `bak_sel_o` and `lock_o` exactly FILT_LEN+3 clock edges after the input changes.
- R11: Synchronous reset gives `lock_o`=1, `pfail_o`=1, `bak_sel_o`=1, `irq_n_o`=1, `acc_grant_o`=0, `reg_rdata_o`=0, flag=1 and enable=0.
- R12: A granted read of any address other than 0x7FF0 returns 0. A granted read returns its data on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok_i | input | 1 | Reference ready (1 = comparators valid) |
| below_warn_i | input | 1 | Supply below warning level (async) |
| below_lock_i | input | 1 | Supply below write-lockout level (async) |
| below_bak_i | input | 1 | Supply below backup source (async) |
| ce_n_i | input | 1 | Chip enable, active low |
| acc_req_i | input | 1 | Memory-array or clock-register access request |
| acc_grant_o | output | 1 | Access granted, one edge after request |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| irq_n_o | output | 1 | Interrupt request, active low |
| pfail_o | output | 1 | Live power-fail condition |
| bak_sel_o | output | 1 | 1 = clock domain on backup supply |
| lock_o | output | 1 | Lockout active |

## Verification
A comparator change takes FILT_LEN+3 edges to reach `pfail_o`, `bak_sel_o` and `lock_o`: two for the synchroniser, FILT_LEN for the filter and one for the output register. The bench changes an input at a falling edge. It confirms that the old value still holds after FILT_LEN+2 rising edges and that the new value is present after FILT_LEN+3. Register reads, grants and the interrupt respond one edge after their strobe, so they are sampled at the falling edge that follows. The exhaustive sweep over the 16 input combinations waits one edge past the full latency before it compares.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int NCH     = 4;
  localparam int CH_RDY  = 0;
  localparam int CH_WARN = 1;
  localparam int CH_LOCK = 2;
  localparam int CH_BAK  = 3;
  localparam int PF_BIT  = 5;
  localparam int IEN_BIT = 0;
  // reset level of each filtered channel: pessimistic (unpowered)
  localparam logic [NCH-1:0] CH_RST = 4'b1110;
endpackage

// File: rtl/pfm_filt.sv
module pfm_filt #(
  parameter int FILT_LEN = 4,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= RST_VAL;
      s2     <= RST_VAL;
      filt_o <= RST_VAL;
      cnt    <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 != filt_o) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          filt_o <= s2;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pfm_lock.sv
module pfm_lock (
  input  logic clk,
  input  logic rst,
  input  logic lock_cond_i,
  input  logic ce_n_i,
  output logic locked_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o <= 1'b1;
      armed    <= 1'b0;
    end else begin
      // entering lockout forgets any earlier deselect
      if (!locked_o && lock_cond_i) armed <= 1'b0;
      else if (ce_n_i)              armed <= 1'b1;

      if (lock_cond_i)                   locked_o <= 1'b1;
      else if (locked_o && (armed || ce_n_i)) locked_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pfm_regs.sv
module pfm_regs #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h7FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_cond_i,
  input  logic              open_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_n_o
);
  import pfm_pkg::*;

  logic              flag, ien, flag_nxt, ien_nxt;
  logic              hit, rd_ok, wr_ok;
  logic [DATA_W-1:0] image;
  logic              wdata_unused;

  assign wdata_unused = ^wdata_i;
  assign hit   = (addr_i == FLAG_ADDR);
  assign rd_ok = rd_i & open_i;
  assign wr_ok = wr_i & open_i & hit;

  always_comb begin
    flag_nxt = pf_cond_i | (flag & ~(rd_ok & hit));
    ien_nxt  = wr_ok ? wdata_i[IEN_BIT] : ien;
    image          = '0;
    image[PF_BIT]  = flag;
    image[IEN_BIT] = ien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b1;
      ien     <= 1'b0;
      rdata_o <= '0;
      irq_n_o <= 1'b1;
    end else begin
      flag    <= flag_nxt;
      ien     <= ien_nxt;
      irq_n_o <= ~(flag_nxt & ien_nxt);
      rdata_o <= (rd_ok && hit) ? image : '0;
    end
  end
endmodule

// File: rtl/pfail_monitor.sv
module pfail_monitor #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                FILT_LEN  = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h7FF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_ok_i,
  input  logic              below_warn_i,
  input  logic              below_lock_i,
  input  logic              below_bak_i,
  input  logic              ce_n_i,
  input  logic              acc_req_i,
  output logic              acc_grant_o,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_n_o,
  output logic              pfail_o,
  output logic              bak_sel_o,
  output logic              lock_o
);
  import pfm_pkg::*;

  logic [NCH-1:0] raw_v, filt_v;
  logic           pf_cond, lock_cond, bak_cond, locked;

  assign raw_v[CH_RDY]  = ref_ok_i;
  assign raw_v[CH_WARN] = below_warn_i;
  assign raw_v[CH_LOCK] = below_lock_i;
  assign raw_v[CH_BAK]  = below_bak_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pfm_filt #(.FILT_LEN(FILT_LEN), .RST_VAL(CH_RST[i])) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_v[i]), .filt_o(filt_v[i])
    );
  end

  // a dead reference means nothing is known: assume the worst
  assign lock_cond = ~filt_v[CH_RDY] | filt_v[CH_LOCK];
  assign pf_cond   = lock_cond | filt_v[CH_WARN];
  assign bak_cond  = ~filt_v[CH_RDY] | filt_v[CH_BAK];

  pfm_lock u_lock (
    .clk(clk), .rst(rst), .lock_cond_i(lock_cond), .ce_n_i(ce_n_i),
    .locked_o(locked)
  );

  pfm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .pf_cond_i(pf_cond), .open_i(~ce_n_i & ~locked),
    .rd_i(reg_rd_i), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  assign lock_o = locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      pfail_o     <= 1'b1;
      bak_sel_o   <= 1'b1;
      acc_grant_o <= 1'b0;
    end else begin
      pfail_o     <= pf_cond;
      bak_sel_o   <= bak_cond;
      acc_grant_o <= acc_req_i & ~ce_n_i & ~locked;
    end
  end
endmodule

// File: rtl/pfail_monitor_chk.sv
module pfail_monitor_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h7FF0
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n_i,
  input logic              acc_grant_o,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              pfail_o,
  input logic              lock_o
);
  import pfm_pkg::*;

  assert_lock_blocks_grant_R3: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> !acc_grant_o);

  assert_lock_blocks_read_R3: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> (reg_rdata_o == '0));

  assert_no_grant_deselected_R3: assert property (@(posedge clk) disable iff (rst)
    ce_n_i |=> !acc_grant_o);

  assert_lock_raises_pfail_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> pfail_o);

  assert_flag_set_on_read_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && !ce_n_i && !lock_o && pfail_o && reg_addr_i == FLAG_ADDR)
      |=> reg_rdata_o[PF_BIT]);
endmodule

bind pfail_monitor pfail_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .acc_grant_o(acc_grant_o),
  .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .pfail_o(pfail_o), .lock_o(lock_o)
);

// File: tb/pfail_monitor_tb.sv
module pfail_monitor_tb;
  localparam int FILT = 3;
  localparam int LAT  = FILT + 3;
  localparam logic [15:0] FA = 16'h7FF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_ok = 1'b1, bw = 1'b0, bl = 1'b0, bb = 1'b0;
  logic ce_n = 1'b1, req = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        grant, irq_n, pfail, bak, lock;
  logic [7:0]  rdata;

  int checks = 0, fails = 0;
  bit flag_m = 1'b1, en_m = 1'b0, lk_m = 1'b1, pf_m = 1'b1;

  always #10 clk = ~clk;

  pfail_monitor #(.FILT_LEN(FILT)) u_dut (
    .clk(clk), .rst(rst), .ref_ok_i(ref_ok), .below_warn_i(bw),
    .below_lock_i(bl), .below_bak_i(bb), .ce_n_i(ce_n), .acc_req_i(req),
    .acc_grant_o(grant), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n),
    .pfail_o(pfail), .bak_sel_o(bak), .lock_o(lock)
  );

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic settle(input logic r, input logic w, input logic l, input logic b);
    @(negedge clk);
    ref_ok = r; bw = w; bl = l; bb = b;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    lk_m = !r || l;
    pf_m = lk_m || w;
    flag_m = flag_m | pf_m;
  endtask

  task automatic do_read(input logic [15:0] a, input string req_s);
    logic [7:0] exp;
    @(negedge clk);
    rd = 1'b1; ce_n = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0; ce_n = 1'b1;
    exp = '0;
    if (!lk_m && a == FA) begin
      exp = {2'b00, flag_m, 4'b0000, en_m};
      flag_m = pf_m;
    end
    chk(req_s, rdata, exp);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; ce_n = 1'b0; addr = FA; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; ce_n = 1'b1;
    if (!lk_m) en_m = d[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 lock", lock, 1); chk("R11 pfail", pfail, 1); chk("R11 bak", bak, 1);
    chk("R11 irq_n", irq_n, 1); chk("R11 grant", grant, 0); chk("R11 rdata", rdata, 0);
    rst = 1'b0;
    settle(1, 0, 0, 0);
    chk("R8 lock released", lock, 0); chk("R1 pfail clear", pfail, 0); chk("R5 bak", bak, 0);
    do_read(FA, "R6 sticky flag from reset");
    do_read(FA, "R6 flag cleared by read");

    // R1 R4 R5 R8 exhaustive sweep of comparator combinations
    for (int v = 0; v < 16; v++) begin
      settle(v[3], v[2], v[1], v[0]);
      chk("R1/R4/R8 pfail", pfail, pf_m);
      chk("R5/R8 bak", bak, v[0] || !v[3]);
      chk("R4/R8 lock", lock, lk_m);
      do_read(FA, "R6/R3 sweep read");
    end
    settle(1, 0, 0, 0);
    do_read(FA, "R6 clear after sweep");

    // R10 exact latency on backup select
    @(negedge clk); bb = 1'b1;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk); chk("R10 bak not yet", bak, 0);
    @(posedge clk);
    @(negedge clk); chk("R10 bak at latency", bak, 1);
    settle(1, 0, 0, 0);
    chk("R5 bak released", bak, 0);

    // R10 glitch shorter than FILT is dropped
    @(negedge clk); bw = 1'b1;
    repeat (FILT - 1) @(posedge clk);
    @(negedge clk); bw = 1'b0;
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk); chk("R10 short pulse", pfail, 0);
    do_read(FA, "R10 short pulse leaves flag clear");
    // pulse of exactly FILT cycles is accepted
    @(negedge clk); bw = 1'b1;
    repeat (FILT) @(posedge clk);
    @(negedge clk); bw = 1'b0;
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    flag_m = 1'b1;
    do_read(FA, "R10 full pulse sets flag");

    // R2 interrupt and R9 set priority
    do_write(8'h01);
    do_read(FA, "R2 enable reads back");
    chk("R2 irq idle", irq_n, 1);
    settle(1, 1, 0, 0);
    chk("R2 irq asserted", irq_n, 0);
    do_read(FA, "R9 read during fail");
    do_read(FA, "R9 flag still set");
    settle(1, 0, 0, 0);
    chk("R6 pfail cleared", pfail, 0);
    chk("R2 irq sticky", irq_n, 0);
    do_read(FA, "R6 flag sticky after recovery");
    chk("R2 irq released by read", irq_n, 1);
    do_read(FA, "R6 flag cleared");

    // R7 and R3: lockout with chip selected throughout
    @(negedge clk); ce_n = 1'b0; bl = 1'b1; bw = 1'b1;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    chk("R3 lock entered", lock, 1);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk); chk("R3 grant blocked", grant, 0);
    req = 1'b0; wr = 1'b1; addr = FA; wdata = 8'h00;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
    bl = 1'b0; bw = 1'b0;
    repeat (LAT + 3) @(posedge clk);
    @(negedge clk);
    chk("R7 lock held without deselect", lock, 1);
    ce_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 lock released after deselect", lock, 0);
    lk_m = 1'b0; pf_m = 1'b0; flag_m = 1'b1;
    do_read(FA, "R3 write ignored during lockout");
    @(negedge clk); ce_n = 1'b0; req = 1'b1;
    @(posedge clk);
    @(negedge clk); chk("R3 grant after release", grant, 1);
    req = 1'b0; ce_n = 1'b1;

    // R12 other address
    do_read(16'h7FF1, "R12 other address");
    finish_run();
  end
endmodule